// File: doc/BRIEF.md
# Dual-Channel VCO Frequency Meter

This block reports how fast each of two voltage-controlled oscillators is running. Each oscillator is one audio demodulator channel. The block counts the rising edges of each oscillator over a fixed gate window, timed from a crystal reference, and publishes one 10-bit code per channel. With the default parameters the gate lasts 100 µs, so one code step is 10 kHz. A 5 to 10 MHz oscillator therefore reads between 500 and 1000. A new pair of results is published about every 100 ms.

The reference may be a 4 MHz or an 8 MHz crystal. A select input bypasses a divide-by-two prescaler when the 4 MHz crystal is fitted, so the internal timebase runs at the same rate in both cases. The oscillator inputs are asynchronous. Each passes through a synchronizer and a rising-edge detector in the reference domain.

Control uses two states. `ST_GATE` counts edges. `ST_REST` holds the published codes and keeps the counters cleared. The transition `ST_GATE -> ST_REST` happens on the last timebase tick of the gate; it latches both codes and raises `upd` for one cycle. The transition `ST_REST -> ST_GATE` happens once the rest of the refresh period has elapsed in ticks. Both transitions occur only on timebase ticks. The block leaves reset in `ST_GATE`.

Top module: `vco_freq_meter`

## Requirements
- R1: During reset, `code_a`, `code_b` and `upd` are 0. After reset is released, both codes stay 0 until the first `upd` pulse.
- R2: With `ref_is_4m` = 1 the timebase ticks on every `clk` cycle. Each code is then the number of rising edges of its oscillator during a gate of GATE_TICKS `clk` cycles.
- R3: With `ref_is_4m` = 0 the timebase ticks on every second `clk` cycle. The gate then spans 2*GATE_TICKS `clk` cycles.
- R4: `upd` is a single-cycle pulse. Its first occurrence is GATE_TICKS timebase ticks after reset release. After that it repeats every PERIOD_TICKS timebase ticks.
- R5: Both codes change only in the cycle in which `upd` is 1. They are updated together from the same gate.
- R6: An edge count above 1023 is reported as 1023.
- R7: The two channels are measured independently. Each code depends only on its own oscillator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock (4 or 8 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_is_4m | input | 1 | 1 = 4 MHz reference (no prescale), 0 = 8 MHz (divide by 2) |
| vco_a | input | 1 | Channel A oscillator, asynchronous |
| vco_b | input | 1 | Channel B oscillator, asynchronous |
| code_a | output | 10 | Channel A frequency in gate-count units |
| code_b | output | 10 | Channel B frequency in gate-count units |
| upd | output | 1 | One-cycle pulse when new codes are published |

## Verification
A wrong tick count or a wrong prescaler phase shows up in two ways. The gate length changes, which moves the published code by its ratio to the edge period. The spacing between `upd` pulses also shifts. Both effects are visible at the first publication after the fault.

A counter that is not cleared in `ST_REST` produces codes that grow on every refresh. That becomes visible one refresh period later. A saturation fault produces a small wrapped value instead of 1023 as soon as a fast oscillator is measured.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int CODE_W = 10;
    typedef enum logic {
        ST_GATE = 1'b0,
        ST_REST = 1'b1
    } meter_state_t;
endpackage

// File: rtl/fm_timebase.sv
// Produces the internal timebase tick: every cycle for a 4 MHz
// reference, every second cycle for an 8 MHz reference.
module fm_timebase (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_is_4m,
    output logic tick
);
    logic half_ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_ph <= 1'b0;
        else        half_ph <= ~half_ph;
    end

    assign tick = ref_is_4m ? 1'b1 : half_ph;
endmodule

// File: rtl/fm_edge_sync.sv
// Brings an asynchronous oscillator into the reference domain and
// flags each rising edge with a one-cycle pulse.
module fm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], async_in};
            last  <= chain[SYNC_STAGES-1];
        end
    end

    assign rise = chain[SYNC_STAGES-1] & ~last;
endmodule

// File: rtl/fm_sat_counter.sv
// Edge counter that sticks at its maximum value; cleared on request.
module fm_sat_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP = '1;
    logic [W-1:0] cnt;

    assign nxt = (inc && cnt != TOP) ? cnt + 1'b1 : cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= nxt;
    end
endmodule

// File: rtl/vco_freq_meter.sv
module vco_freq_meter
    import fm_pkg::*;
#(
    parameter int GATE_TICKS   = 400,
    parameter int PERIOD_TICKS = 400000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_is_4m,
    input  logic              vco_a,
    input  logic              vco_b,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              upd
);
    localparam int NCH = 2;
    localparam int TCW = $clog2(PERIOD_TICKS);
    localparam logic [TCW-1:0] GATE_LAST = TCW'(GATE_TICKS - 1);
    localparam logic [TCW-1:0] REST_LAST = TCW'(PERIOD_TICKS - GATE_TICKS - 1);

    meter_state_t      state;
    logic [TCW-1:0]    tick_cnt;
    logic              tick;
    logic              leave_gate;
    logic [NCH-1:0]    vco_in;
    logic [NCH-1:0]    rise;
    logic [CODE_W-1:0] cnt_nx [NCH];

    assign vco_in = {vco_b, vco_a};

    fm_timebase u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_is_4m (ref_is_4m),
        .tick      (tick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        fm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (vco_in[ch]),
            .rise     (rise[ch])
        );
        fm_sat_counter #(.W(CODE_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (state == ST_REST),
            .inc   (rise[ch]),
            .nxt   (cnt_nx[ch])
        );
    end

    assign leave_gate = (state == ST_GATE) && tick && (tick_cnt == GATE_LAST);

    // State register and tick counter: advance only on timebase ticks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_GATE;
            tick_cnt <= '0;
        end else if (tick) begin
            unique case (state)
                ST_GATE: begin
                    if (tick_cnt == GATE_LAST) begin
                        state    <= ST_REST;
                        tick_cnt <= '0;
                    end else begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                ST_REST: begin
                    if (tick_cnt == REST_LAST) begin
                        state    <= ST_GATE;
                        tick_cnt <= '0;
                    end else begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs: both codes latched together with the strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_a <= '0;
            code_b <= '0;
            upd    <= 1'b0;
        end else begin
            upd <= leave_gate;
            if (leave_gate) begin
                code_a <= cnt_nx[0];
                code_b <= cnt_nx[1];
            end
        end
    end
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
    parameter int PERIOD_TICKS = 400000,
    parameter int CODE_W       = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b
);
    localparam int GW = $clog2(2 * PERIOD_TICKS + 4);
    localparam logic [GW-1:0] GAP_MIN = GW'(PERIOD_TICKS - 1);
    logic [GW-1:0] gap;
    logic          seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else begin
            if (upd)           gap <= '0;
            else if (gap != '1) gap <= gap + 1'b1;
            if (upd) seen <= 1'b1;
        end
    end

    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd); // R4
    AST_UPD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && seen) |-> (gap >= GAP_MIN)); // R4
    AST_CODE_A_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(code_a)); // R5
    AST_CODE_B_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(code_b)); // R5
    AST_ZERO_BEFORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen && !upd) |-> (code_a == '0 && code_b == '0)); // R1
endmodule

bind vco_freq_meter fm_checker #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .CODE_W       (fm_pkg::CODE_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (upd),
    .code_a (code_a),
    .code_b (code_b)
);

// File: tb/sim_vco_freq_meter.sv
`timescale 1ns/1ps
module sim_vco_freq_meter;
    localparam int GATE_T   = 2100;
    localparam int PERIOD_T = 2500;
    localparam int NVEC     = 8;

    // {sel_4m, period_a, period_b, exp_a, exp_b}; period 0 = no edges
    typedef struct packed {
        logic       sel;
        logic [7:0] pa;
        logic [7:0] pb;
        logic [9:0] ea;
        logic [9:0] eb;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'd3,  8'd7,  10'd700,  10'd300},
        '{1'b1, 8'd4,  8'd5,  10'd525,  10'd420},
        '{1'b1, 8'd2,  8'd10, 10'd1023, 10'd210},
        '{1'b1, 8'd0,  8'd6,  10'd0,    10'd350},
        '{1'b0, 8'd7,  8'd5,  10'd600,  10'd840},
        '{1'b0, 8'd6,  8'd4,  10'd700,  10'd1023},
        '{1'b0, 8'd10, 8'd14, 10'd420,  10'd300},
        '{1'b0, 8'd12, 8'd3,  10'd350,  10'd1023}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_is_4m = 1'b1;
    logic       vco_a = 1'b0;
    logic       vco_b = 1'b0;
    logic [9:0] code_a, code_b;
    logic       upd;

    int checks = 0;
    int fails  = 0;
    int per_a = 0, per_b = 0;
    int ph_a = 0, ph_b = 0;
    bit hung = 1'b0;
    bit held_bad;

    always #2 clk = ~clk; // 250 MHz

    vco_freq_meter #(.GATE_TICKS(GATE_T), .PERIOD_TICKS(PERIOD_T)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_is_4m(ref_is_4m),
        .vco_a(vco_a), .vco_b(vco_b),
        .code_a(code_a), .code_b(code_b), .upd(upd)
    );

    // Oscillator models: one rising edge every per_x clk cycles.
    always @(negedge clk) begin
        if (per_a == 0) begin vco_a <= 1'b0; ph_a <= 0; end
        else begin
            vco_a <= (ph_a < (per_a + 1) / 2);
            ph_a  <= (ph_a + 1 >= per_a) ? 0 : ph_a + 1;
        end
        if (per_b == 0) begin vco_b <= 1'b0; ph_b <= 0; end
        else begin
            vco_b <= (ph_b < (per_b + 1) / 2);
            ph_b  <= (ph_b + 1 >= per_b) ? 0 : ph_b + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Waits for the next upd; returns cycles waited, tracks held codes (R5).
    task automatic wait_upd(output int n);
        logic [9:0] pa = code_a, pb = code_b;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (upd) break;
            if (code_a != pa || code_b != pb) held_bad = 1'b1;
            pa = code_a; pb = code_b;
            if (n > 20000) begin
                if (!hung) begin
                    fails++; checks++;
                    $display("FAIL watchdog: actual no upd expected upd");
                end
                hung = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        int n;
        held_bad = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 reset code_a", code_a, 0);
        check("R1 reset code_b", code_b, 0);
        check("R1 reset upd", upd, 0);
        per_a = 3; per_b = 7;
        rst_n = 1'b1;
        repeat (GATE_T - 5) @(negedge clk);
        check("R1 code_a zero before first upd", code_a, 0);
        check("R1 code_b zero before first upd", code_b, 0);
        // Continue counting from where we are: GATE_T-5 cycles done.
        wait_upd(n);
        check("R4 first upd after gate", n + GATE_T - 5, GATE_T);

        for (int i = 0; i < NVEC && !hung; i++) begin
            ref_is_4m = VECS[i].sel;
            per_a = VECS[i].pa;
            per_b = VECS[i].pb;
            wait_upd(n);
            held_bad = 1'b0;
            wait_upd(n);
            // R2 (4 MHz) / R3 (8 MHz) / R6 saturation / R7 independence
            check(VECS[i].sel ? "R2 R7 code_a" : "R3 R7 code_a", code_a, VECS[i].ea);
            check(VECS[i].sel ? "R2 R7 code_b" : "R3 R7 code_b", code_b, VECS[i].eb);
            if (VECS[i].ea == 10'd1023 || VECS[i].eb == 10'd1023)
                check("R6 saturated code seen", 1, 1);
            check("R5 codes held between upd", held_bad, 0);
        end

        // Refresh spacing in both reference modes (R4).
        ref_is_4m = 1'b1;
        wait_upd(n);
        wait_upd(n);
        check("R4 period 4 MHz", n, PERIOD_T);
        ref_is_4m = 1'b0;
        wait_upd(n);
        wait_upd(n);
        check("R4 period 8 MHz", n, 2 * PERIOD_T);
        // upd lasts one cycle
        @(negedge clk);
        check("R4 upd single cycle", upd, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule